// File: doc/BRIEF.md
# Transmit Dominant Time-out Guard

This block sits between a protocol controller and the driver stage of a two-wire bus transceiver. It watches the transmit data line, where low means dominant, and produces the command that actually drives the bus dominant. If the transmit line stays low for too long, the block withdraws that command so the bus falls back to recessive. This covers a stuck controller or a broken trace, either of which would otherwise block every node on the segment. It also raises a fault flag. A mode input holds the driver off completely while the transceiver is in its low-power mode.

Both asynchronous inputs pass through a two-flop synchronizer. A saturating counter measures how long the synchronized transmit line has been low. Any high sample clears the counter at once. When the count passes the limit `TIMEOUT_CYCLES`, the driver is locked off and the fault flag is set. Both stay in that state until one high sample of the transmit line is seen. After that, a new low may drive the bus again.

The limit is given in clock cycles. It must be chosen above the longest legal dominant run at the lowest supported bit rate, which is 40 kbit/s.

Top module: `txd_timeout_guard`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `drv_dominant_o` and `fault_o` are 0.
- R2: `txd_in` and `standby_in` are each synchronized through two flops. A low `txd_in` first sampled at rising edge k (with `standby_in` low and no fault) makes `drv_dominant_o` 1 after edge k+2.
- R3: If `txd_in` stays low, `drv_dominant_o` stays 1 for exactly `TIMEOUT_CYCLES` cycles. It drops to 0 after edge k+`TIMEOUT_CYCLES`+2, and `fault_o` rises after that same edge.
- R4: A low run of exactly `TIMEOUT_CYCLES` consecutive samples never sets `fault_o`. A run of `TIMEOUT_CYCLES`+1 samples does.
- R5: A single high sample clears the low-time count. The next low run is timed afresh from zero.
- R6: After a time-out, `drv_dominant_o` stays 0 for as long as `txd_in` stays low. `fault_o` and `drv_dominant_o` are never 1 in the same cycle.
- R7: One high sample of `txd_in` at edge h clears `fault_o` after edge h+2. A low sampled at h+1 then drives `drv_dominant_o` to 1 after edge h+3.
- R8: `standby_in` high, once synchronized, forces `drv_dominant_o` to 0. The low-time counter keeps running, so a time-out can still occur in that mode.
- R9: At every cycle, `drv_dominant_o` and `fault_o` match a cycle-level model of R2 to R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| txd_in | input | 1 | Transmit data from controller, low = dominant (asynchronous) |
| standby_in | input | 1 | Low-power mode select, high = driver held off (asynchronous) |
| drv_dominant_o | output | 1 | Registered command, 1 = drive bus dominant |
| fault_o | output | 1 | Registered time-out fault flag |

## Verification
A counter that is off by one shows up at the ports as a dominant window one cycle longer or shorter than `TIMEOUT_CYCLES`. It also moves the fault edge by one cycle, so the directed runs of `TIMEOUT_CYCLES` and `TIMEOUT_CYCLES`+1 low samples expose it on the first time-out. A lock that fails to clear, or clears too early, is visible within three cycles of the first high sample. It shows as `fault_o` stuck high, or as `drv_dominant_o` returning while the line is still low. A missing synchronizer stage shifts every output edge by one cycle, and the per-cycle model catches that from the first transition.

// File: rtl/txg_pkg.sv
package txg_pkg;
  typedef enum logic {
    TXG_ARMED  = 1'b0,
    TXG_LOCKED = 1'b1
  } txg_state_e;
endpackage

// File: rtl/txg_sync.sv
module txg_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH = 1,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= RESET_VAL;
    else     stage_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[g] <= RESET_VAL;
      else     stage_q[g] <= stage_q[g-1];
    end

    assert_stage_shift_R2: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> stage_q[g] == $past(stage_q[g-1]));
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/txg_low_timer.sv
module txg_low_timer #(
  parameter int unsigned TIMEOUT_CYCLES = 1000,
  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic txd_s_i,
  output logic expire_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYCLES);

  logic [CNT_W-1:0] low_cnt_q;
  logic             at_limit;

  assign at_limit = (low_cnt_q == LIMIT);
  assign expire_o = ~txd_s_i & at_limit;

  always_ff @(posedge clk) begin
    if (rst || txd_s_i) low_cnt_q <= '0;
    else if (!at_limit) low_cnt_q <= low_cnt_q + 1'b1;
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    low_cnt_q <= LIMIT);
  assert_high_clears_R5: assert property (@(posedge clk) disable iff (rst)
    txd_s_i |=> low_cnt_q == '0);
  assert_low_advances_R3: assert property (@(posedge clk) disable iff (rst)
    (!txd_s_i && !at_limit) |=> low_cnt_q == $past(low_cnt_q) + 1'b1);
endmodule

// File: rtl/txg_gate.sv
module txg_gate
  import txg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic txd_s_i,
  input  logic standby_s_i,
  input  logic expire_i,
  output logic drv_o,
  output logic fault_o
);
  txg_state_e state_q;
  logic       drv_q;
  logic       fault_q;
  logic       drive_ok;

  assign drive_ok = ~standby_s_i & ~txd_s_i & (state_q == TXG_ARMED) & ~expire_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TXG_ARMED;
      fault_q <= 1'b0;
      drv_q   <= 1'b0;
    end else begin
      if (txd_s_i) begin
        state_q <= TXG_ARMED;
        fault_q <= 1'b0;
      end else if (expire_i) begin
        state_q <= TXG_LOCKED;
        fault_q <= 1'b1;
      end
      drv_q <= drive_ok;
    end
  end

  assign drv_o   = drv_q;
  assign fault_o = fault_q;

  assert_expire_sets_fault_R3: assert property (@(posedge clk) disable iff (rst)
    expire_i |=> fault_q && !drv_q);
  assert_no_drive_in_fault_R6: assert property (@(posedge clk) disable iff (rst)
    !(fault_q && drv_q));
  assert_fault_clear_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_q) |-> $past(txd_s_i));
  assert_standby_off_R8: assert property (@(posedge clk) disable iff (rst)
    standby_s_i |=> !drv_q);
endmodule

// File: rtl/txd_timeout_guard.sv
module txd_timeout_guard #(
  parameter int unsigned TIMEOUT_CYCLES = 1000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic txd_in,
  input  logic standby_in,
  output logic drv_dominant_o,
  output logic fault_o
);
  logic [1:0] raw_in;
  logic [1:0] synced;
  logic       txd_s;
  logic       standby_s;
  logic       expire;

  assign raw_in = {standby_in, txd_in};

  txg_sync #(
    .STAGES   (SYNC_STAGES),
    .WIDTH    (2),
    .RESET_VAL(2'b11)
  ) sync_i (
    .clk(clk),
    .rst(rst),
    .d_i(raw_in),
    .q_o(synced)
  );

  assign txd_s     = synced[0];
  assign standby_s = synced[1];

  txg_low_timer #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) timer_i (
    .clk     (clk),
    .rst     (rst),
    .txd_s_i (txd_s),
    .expire_o(expire)
  );

  txg_gate gate_i (
    .clk        (clk),
    .rst        (rst),
    .txd_s_i    (txd_s),
    .standby_s_i(standby_s),
    .expire_i   (expire),
    .drv_o      (drv_dominant_o),
    .fault_o    (fault_o)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !drv_dominant_o && !fault_o);
endmodule

// File: tb/txd_timeout_guard_tb.sv
`timescale 1ns/1ps
module txd_timeout_guard_tb_top;
  localparam int unsigned T = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic txd_in = 1'b1;
  logic standby_in = 1'b0;
  logic drv_dominant_o;
  logic fault_o;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  txd_timeout_guard #(.TIMEOUT_CYCLES(T), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .txd_in(txd_in), .standby_in(standby_in),
    .drv_dominant_o(drv_dominant_o), .fault_o(fault_o)
  );

  // cycle-level model built from the requirements
  logic m_tx1, m_tx2, m_sb1, m_sb2;
  int   m_run;
  logic m_lock, m_drv, m_fault;

  function automatic logic next_drv(logic sb, logic tx, logic lock, int run);
    return !sb && !tx && !lock && !(run == T);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_tx1 = 1; m_tx2 = 1; m_sb1 = 1; m_sb2 = 1;
      m_run = 0; m_lock = 0; m_drv = 0; m_fault = 0;
    end else begin
      m_drv = next_drv(m_sb2, m_tx2, m_lock, m_run);
      if (m_tx2) begin
        m_run = 0; m_lock = 0; m_fault = 0;
      end else if (m_run == T) begin
        m_lock = 1; m_fault = 1;
      end else begin
        m_run = m_run + 1;
      end
      m_tx2 = m_tx1; m_tx1 = txd_in;
      m_sb2 = m_sb1; m_sb1 = standby_in;
    end
  end

  task automatic check(input logic act, input logic exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", what, act, exp, $time);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      check(drv_dominant_o, m_drv, "R9 drv model");
      check(fault_o, m_fault, "R9 fault model");
    end
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    check(drv_dominant_o, 1'b0, "R1 drv in reset");
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step(1);
    check(drv_dominant_o, 1'b0, "R1 drv after reset");
    check(fault_o, 1'b0, "R1 fault after reset");
    step(4);

    // R2 / R3: latency, dominant window and expiry edge
    txd_in = 1'b0;
    step(2);
    check(drv_dominant_o, 1'b0, "R2 still off after edge k+1");
    step(1);
    check(drv_dominant_o, 1'b1, "R2 on after edge k+2");
    step(T - 1);
    check(drv_dominant_o, 1'b1, "R3 on at last window cycle");
    check(fault_o, 1'b0, "R3 no fault before limit");
    step(1);
    check(drv_dominant_o, 1'b0, "R3 released at limit");
    check(fault_o, 1'b1, "R3 fault at limit");

    // R6: stays locked while low
    step(10);
    check(drv_dominant_o, 1'b0, "R6 held off while low");
    check(fault_o, 1'b1, "R6 fault held");

    // R7: single high sample re-arms
    txd_in = 1'b1;
    step(1);
    txd_in = 1'b0;
    step(1);
    check(fault_o, 1'b1, "R7 fault until h+2");
    step(1);
    check(fault_o, 1'b0, "R7 fault cleared h+2");
    check(drv_dominant_o, 1'b0, "R7 drv off at h+2");
    step(1);
    check(drv_dominant_o, 1'b1, "R7 drive again h+3");
    txd_in = 1'b1;
    step(5);

    // R4: exactly T low samples, no fault
    txd_in = 1'b0;
    step(T);
    txd_in = 1'b1;
    step(5);
    check(fault_o, 1'b0, "R4 T samples no fault");
    // R4: T+1 low samples, fault
    txd_in = 1'b0;
    step(T + 1);
    txd_in = 1'b1;
    step(2);
    check(fault_o, 1'b1, "R4 T+1 samples fault");
    step(5);

    // R5: high sample restarts timing
    txd_in = 1'b0;
    step(T - 2);
    txd_in = 1'b1;
    step(1);
    txd_in = 1'b0;
    step(T);
    txd_in = 1'b1;
    step(5);
    check(fault_o, 1'b0, "R5 restart no fault");

    // R8: standby holds off, counter still runs
    standby_in = 1'b1;
    step(3);
    txd_in = 1'b0;
    step(5);
    check(drv_dominant_o, 1'b0, "R8 standby off");
    step(T);
    check(fault_o, 1'b1, "R8 timeout in standby");
    txd_in = 1'b1;
    standby_in = 1'b0;
    step(5);

    // random phase
    for (int seg = 0; seg < 300; seg++) begin
      int len;
      if (($urandom % 8) == 0) standby_in = ~standby_in;
      txd_in = ~txd_in;
      if (txd_in == 1'b0) len = 1 + ($urandom % (T + 6));
      else                len = 1 + ($urandom % 4);
      step(len);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule